// File: doc/BRIEF.md
# Read-Snooping Data Terminator Control

This block runs inside a memory device that shares its command bus with a second rank. It watches every command on the bus and recognises reads from the row strobe, column strobe and write enable alone. It has no chip-select input, so a read meant for the other rank is caught just like a read meant for this one. Each read schedules a stretch of clock cycles in which the device turns its data-line terminators off. The stretch opens a programmable number of cycles after the read, which is the CAS latency less one, and lasts four cycles. Reads that come close together produce disable stretches that overlap or touch, and these merge into one continuous stretch. The command and address terminators are never switched off.

Detected reads pass down a one-bit delay line. A tap chosen by the CAS latency feeds a two-state window machine. In state `WIN_ON` the data terminators are enabled. In state `WIN_OFF` they are disabled and a hold counter runs down. The named transitions are `ARM` (WIN_ON to WIN_OFF when the tap fires), `EXTEND` (WIN_OFF stays in WIN_OFF and the counter reloads when the tap fires), `HOLD` (WIN_OFF stays in WIN_OFF and the counter decrements) and `RELEASE` (WIN_OFF to WIN_ON when the counter has run out). Reset clears the delay line and forces `WIN_ON`.

Top module: `dts_snoop_top`

## Requirements
- R1: A read is the bus pattern ras_n=1, cas_n=0, we_n=1, sampled at a rising clock edge. There is no chip-select qualification. For a read sampled at edge n with latency CL, dterm_en is low in the cycles that follow edges n+CL-1 through n+CL+2.
- R2: No other pattern disables the data terminators. This covers 111 (no operation), 011 (activate), 100 (write), 010 (precharge), 001 (refresh), 000 (mode set) and 110 (burst stop), given as {ras_n,cas_n,we_n}.
- R3: A read with no other read near it gives a disabled stretch of exactly 4 cycles.
- R4: Reads whose stretches overlap or touch give one continuous low period. It starts at the first read's start cycle and ends at the last read's end cycle, with no high cycle in between.
- R5: When one read's stretch ends before the next read's stretch starts, dterm_en is high in the cycles between them.
- R6: caterm_en is 1 in every cycle, both during reset and after it.
- R7: While rst_n is low, dterm_en is 1. Reads in flight when reset is asserted produce no disabled stretch after reset is released.
- R8: cas_lat selects CL from 4 to 12. A value below 4 acts as 4, and a value above 12 acts as 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe from the shared command bus, active low |
| cas_n | input | 1 | Column strobe from the shared command bus, active low |
| we_n | input | 1 | Write enable from the shared command bus, active low |
| cas_lat | input | 4 | Programmed CAS latency in clocks |
| dterm_en | output | 1 | Data terminator enable; low while disabled |
| caterm_en | output | 1 | Command/address terminator enable; always high |

## Verification
The assertions assume that cas_lat does not change while a read is still in flight or while a disabled stretch is open. They also assume that the command pins are always at a defined level, never X or Z, once reset is released. The bench changes cas_lat only after a run of no-operation cycles that drains the delay line. It drives the command pins on the falling edge with defined values in every cycle. Every scenario ends with enough idle cycles that each window closes before the next scenario starts.

// File: rtl/dts_pkg.sv
`timescale 1ns/1ps
package dts_pkg;

    typedef enum logic {
        WIN_ON  = 1'b0,
        WIN_OFF = 1'b1
    } win_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } bus_cmd_t;

    localparam bus_cmd_t BUS_RD = '{ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/dts_cmd_decode.sv
`timescale 1ns/1ps
module dts_cmd_decode
    import dts_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_cmd_t cmd,
    output logic     rd_seen
);
    logic rd_now;

    // Chip select plays no part: any read on the shared bus counts.
    always_comb begin
        rd_now = (cmd == BUS_RD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_seen <= 1'b0;
        else        rd_seen <= rd_now;
    end
endmodule

// File: rtl/dts_lat_select.sv
`timescale 1ns/1ps
module dts_lat_select #(
    parameter int MIN_CL = 4,
    parameter int MAX_CL = 12,
    parameter int CLW    = 4,
    parameter int TAPW   = 4
) (
    input  logic [CLW-1:0]  cas_lat,
    output logic [TAPW-1:0] tap_idx
);
    logic [CLW-1:0] cl_eff;

    always_comb begin
        if (cas_lat < CLW'(MIN_CL))      cl_eff = CLW'(MIN_CL);
        else if (cas_lat > CLW'(MAX_CL)) cl_eff = CLW'(MAX_CL);
        else                             cl_eff = cas_lat;
        // Decode register plus window register absorb two edges.
        tap_idx = TAPW'(cl_eff - CLW'(2));
    end
endmodule

// File: rtl/dts_read_pipe.sv
`timescale 1ns/1ps
module dts_read_pipe #(
    parameter int DEPTH = 11,
    parameter int TAPW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_seen,
    input  logic [TAPW-1:0] tap_idx,
    output logic            fire
);
    logic [DEPTH-1:0] taps;

    assign taps[0] = rd_seen;

    genvar g;
    generate
        for (g = 1; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) taps[g] <= 1'b0;
                else        taps[g] <= taps[g-1];
            end
        end
    endgenerate

    always_comb begin
        fire = taps[tap_idx];
    end
endmodule

// File: rtl/dts_window_fsm.sv
`timescale 1ns/1ps
module dts_window_fsm
    import dts_pkg::*;
#(
    parameter int WIN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic term_on
);
    localparam int CW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;

    win_state_e     state_q, state_d;
    logic [CW-1:0]  hold_q, hold_d;

    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        unique case (state_q)
            WIN_ON: begin
                if (fire) begin                 // ARM
                    state_d = WIN_OFF;
                    hold_d  = CW'(WIN_LEN - 1);
                end
            end
            WIN_OFF: begin
                if (fire) begin                 // EXTEND
                    hold_d = CW'(WIN_LEN - 1);
                end else if (hold_q == '0) begin // RELEASE
                    state_d = WIN_ON;
                end else begin                  // HOLD
                    hold_d = hold_q - CW'(1);
                end
            end
            default: state_d = WIN_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_ON;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        unique case (state_q)
            WIN_ON:  term_on = 1'b1;
            WIN_OFF: term_on = 1'b0;
            default: term_on = 1'b1;
        endcase
    end
endmodule

// File: rtl/dts_snoop_top.sv
`timescale 1ns/1ps
module dts_snoop_top
    import dts_pkg::*;
#(
    parameter int MIN_CL  = 4,
    parameter int MAX_CL  = 12,
    parameter int CLW     = 4,
    parameter int WIN_LEN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ras_n,
    input  logic           cas_n,
    input  logic           we_n,
    input  logic [CLW-1:0] cas_lat,
    output logic           dterm_en,
    output logic           caterm_en
);
    localparam int DEPTH = MAX_CL - 1;
    localparam int TAPW  = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    bus_cmd_t        cmd;
    logic            rd_seen;
    logic [TAPW-1:0] tap_idx;
    logic            fire;
    logic            term_on;

    assign cmd = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    dts_cmd_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .rd_seen (rd_seen)
    );

    dts_lat_select #(
        .MIN_CL (MIN_CL),
        .MAX_CL (MAX_CL),
        .CLW    (CLW),
        .TAPW   (TAPW)
    ) u_lat (
        .cas_lat (cas_lat),
        .tap_idx (tap_idx)
    );

    dts_read_pipe #(
        .DEPTH (DEPTH),
        .TAPW  (TAPW)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_seen (rd_seen),
        .tap_idx (tap_idx),
        .fire    (fire)
    );

    dts_window_fsm #(
        .WIN_LEN (WIN_LEN)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .term_on (term_on)
    );

    assign dterm_en  = term_on;
    assign caterm_en = 1'b1;
endmodule

// File: rtl/dts_checker.sv
`timescale 1ns/1ps
module dts_checker #(
    parameter int MIN_CL  = 4,
    parameter int MAX_CL  = 12,
    parameter int CLW     = 4,
    parameter int WIN_LEN = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ras_n,
    input logic           cas_n,
    input logic           we_n,
    input logic [CLW-1:0] cas_lat,
    input logic           dterm_en,
    input logic           caterm_en
);
    localparam int HW = MAX_CL + WIN_LEN;

    logic [HW-1:0]  rd_hist;
    logic [7:0]     low_run;
    logic [CLW-1:0] lat;
    logic           is_rd;

    assign is_rd = ras_n & ~cas_n & we_n;
    assign lat   = (cas_lat > CLW'(MAX_CL)) ? CLW'(MAX_CL) :
                   ((cas_lat < CLW'(MIN_CL)) ? CLW'(MIN_CL) : cas_lat);

    // rd_hist[j] at an edge = a read was seen j+1 edges earlier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_hist <= '0;
        else        rd_hist <= {rd_hist[HW-2:0], is_rd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         low_run <= '0;
        else if (dterm_en)  low_run <= '0;
        else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
    end

    // R1: a window opens only CL edges after a read sample
    assert_open_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dterm_en) |-> rd_hist[lat - CLW'(1)]);

    // R4 / R2 / R5: output equals the union of all read windows
    assert_union_of_windows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dterm_en == ~(|rd_hist[lat - CLW'(1) +: WIN_LEN]));

    // R3: no disabled stretch shorter than the window length
    assert_min_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dterm_en) |-> (low_run >= 8'(WIN_LEN)));

    // R6: command/address terminators never switch off
    assert_ca_term_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        caterm_en == 1'b1);

    // R7: first sample after reset release shows terminators enabled
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> dterm_en);
endmodule

bind dts_snoop_top dts_checker #(
    .MIN_CL  (MIN_CL),
    .MAX_CL  (MAX_CL),
    .CLW     (CLW),
    .WIN_LEN (WIN_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cas_lat   (cas_lat),
    .dterm_en  (dterm_en),
    .caterm_en (caterm_en)
);

// File: tb/dts_snoop_top_tb_top.sv
`timescale 1ns/1ps
module dts_snoop_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic [3:0] cas_lat = 4'd4;
    logic       dterm_en;
    logic       caterm_en;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dts_snoop_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .cas_lat   (cas_lat),
        .dterm_en  (dterm_en),
        .caterm_en (caterm_en)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // {ras_n,cas_n,we_n}: the non-read patterns of R2, in rotation
    function automatic logic [2:0] filler(int k, bit rotate);
        logic [2:0] tbl [7] = '{3'b111, 3'b011, 3'b100, 3'b010, 3'b001, 3'b000, 3'b110};
        return rotate ? tbl[k % 7] : 3'b111;
    endfunction

    function automatic logic exp_low(logic [63:0] mask, int cl, int k);
        for (int n = 0; n < 64; n++)
            if (mask[n] && k >= n + cl - 1 && k <= n + cl + 2) return 1'b1;
        return 1'b0;
    endfunction

    // Pattern slot k is sampled at edge k; output after that edge is seen
    // at the following falling edge.
    task automatic run_pat(string req, int cl_set, int cl_eff,
                           logic [63:0] mask, int len, bit rotate);
        cas_lat = 4'(cl_set);
        for (int k = 0; k <= len; k++) begin
            @(negedge clk);
            if (k > 0) begin
                check(req, $sformatf("dterm_en slot %0d", k - 1), dterm_en,
                      ~exp_low(mask, cl_eff, k - 1));
                check("R6", "caterm_en", caterm_en, 1'b1);
            end
            if (k < len && mask[k]) {ras_n, cas_n, we_n} = 3'b101;
            else                    {ras_n, cas_n, we_n} = filler(k, rotate);
        end
        {ras_n, cas_n, we_n} = 3'b111;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R7", "dterm_en in reset", dterm_en, 1'b1);
        check("R6", "caterm_en in reset", caterm_en, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "dterm_en after release", dterm_en, 1'b1);
    endtask

    task automatic t_single_min();   run_pat("R1", 4, 4, 64'h4, 20, 0);  endtask
    task automatic t_single_max();   run_pat("R3", 12, 12, 64'h4, 30, 0); endtask
    task automatic t_back_to_back(); run_pat("R4", 7, 7, 64'hC, 24, 0);  endtask
    task automatic t_staggered();    run_pat("R4", 6, 6, 64'h54, 24, 1); endtask
    task automatic t_gap();          run_pat("R5", 5, 5, 64'h84, 24, 0); endtask
    task automatic t_no_reads();     run_pat("R2", 9, 9, 64'h0, 28, 1);  endtask
    task automatic t_clamp_low();    run_pat("R8", 2, 4, 64'h4, 20, 0);  endtask
    task automatic t_clamp_high();   run_pat("R8", 15, 12, 64'h4, 30, 1); endtask
    task automatic t_other_rank();   run_pat("R1", 8, 8, 64'h1004, 32, 1); endtask

    task automatic t_reset_flush();
        cas_lat = 4'd8;
        @(negedge clk);
        {ras_n, cas_n, we_n} = 3'b101;
        @(negedge clk);
        {ras_n, cas_n, we_n} = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7", "dterm_en held in reset", dterm_en, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R7", $sformatf("flushed read, cycle %0d", i), dterm_en, 1'b1);
        end
    endtask

    initial begin
        t_reset_state();
        t_single_min();
        t_single_max();
        t_back_to_back();
        t_staggered();
        t_gap();
        t_no_reads();
        t_clamp_low();
        t_clamp_high();
        t_other_rank();
        t_reset_flush();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule